// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds a set of 32-bit event counters and one free-running cycle counter for performance monitoring. Each event counter is given an event number and two privilege filter bits. On every clock in which the chosen event line pulses, the counter's enable is set, the global enable is set and the current privilege level is not excluded, the counter adds one. When a counter wraps from all ones to zero, a sticky overflow flag is set. A level interrupt is raised while any flagged counter also has its interrupt enabled.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge and reads are combinational. Counter enables and interrupt enables each appear at two addresses: one sets bits, the other clears them, and both read back the same mask. Every counter can be accessed at its own type and value addresses. It can also be accessed through a window that follows a selection register. The cycle counter can be slowed by a divide-by-64 prescaler.

Top module: `perf_counter_bank`

## Requirements
- R1: Control register at address 0x00: bit 0 global enable, bit 3 divider, bit 4 export, bit 5 region-disable are stored and read back. Bits 1 and 2 read 0. Bit 6 reads 1. Bits 15:11 read NUM_CTR. All other bits read 0.
- R2: Writing control bit 1 clears every event counter. Writing control bit 2 clears the cycle counter and its prescaler. Each clear wins over a same-cycle increment.
- R3: Writing ones to address 0x01 sets counter enables, and writing ones to 0x02 clears them. Both addresses read the same mask. Only bits below NUM_CTR and bit 31 (the cycle counter) can become 1.
- R4: Event counter n adds one in a cycle where control bit 0, enable bit n and event line evt_pulse[e] are all 1, with e being the counter's event number. An event number of NUM_EVT or more never counts.
- R5: Type bit 31 blocks counting while priv_lvl is 1. Type bit 30 blocks counting while priv_lvl is 0.
- R6: A wrap from 0xFFFFFFFF to 0 sets overflow bit n (bit 31 for the cycle counter) at address 0x05. Writing ones there clears those bits, but a wrap in the same cycle keeps its bit set.
- R7: Interrupt enables use set address 0x03 and clear address 0x04, with the same semantics and masking as R3. irq is 1 exactly when some bit is set in both the overflow flags and the interrupt enables.
- R8: The selection register is at 0x06 (bits 4:0). Addresses 0x07 and 0x08 read and write the type and value of the selected counter. A selection of NUM_CTR or above reads 0 there and ignores writes.
- R9: Counter n's type register is at 0x20+n and keeps bits 31, 30 and 15:0, with other bits reading 0. Any event number is accepted. Its value register is at 0x40+n and returns what was written.
- R10: A value write to a counter in the same cycle as an increment of that counter stores the written value.
- R11: The cycle counter is at 0x09 and is writable. It adds one per clock while control bit 0 and enable bit 31 are set. With control bit 3 set, it adds one once every 64 enabled clocks.
- R12: After reset, all counters, enables, flags and the selection read 0, control reads only its fixed bits, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 7 | Register address, shared by reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_pulse | input | NUM_EVT | One pulse line per event number |
| priv_lvl | input | 1 | Current privilege level (0 or 1) |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench drives a counter to within a few counts of the wrap point and checks that the count lands exactly and that only that counter's flag is set. A design with an off-by-one wrap, or one that flags the wrong bit, fails here. The bench also lines up a flag clear with a new wrap, and a value write with an event pulse, in the same cycle. An implementation that gives priority to the wrong side either loses an overflow or lets the increment overwrite the written value. It also writes all ones to the enable pairs, programs unsupported event numbers, uses out-of-range window selections, and sets each privilege exclusion bit. A design that leaks unimplemented enable bits, counts phantom events, or writes through an invalid window shows a mismatch at the read port. Random traffic against a reference model covers the divider, the filters and the clears in mixed order.

// File: rtl/pmu_bank_pkg.sv
package pmu_bank_pkg;

    localparam int unsigned ADDR_W = 7;
    localparam int unsigned WORD_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL     = 7'h00;
    localparam logic [ADDR_W-1:0] A_CEN_SET  = 7'h01;
    localparam logic [ADDR_W-1:0] A_CEN_CLR  = 7'h02;
    localparam logic [ADDR_W-1:0] A_IEN_SET  = 7'h03;
    localparam logic [ADDR_W-1:0] A_IEN_CLR  = 7'h04;
    localparam logic [ADDR_W-1:0] A_OVF      = 7'h05;
    localparam logic [ADDR_W-1:0] A_SEL      = 7'h06;
    localparam logic [ADDR_W-1:0] A_SEL_TYPE = 7'h07;
    localparam logic [ADDR_W-1:0] A_SEL_VAL  = 7'h08;
    localparam logic [ADDR_W-1:0] A_CYC      = 7'h09;
    localparam logic [ADDR_W-1:0] A_TYPE_BASE = 7'h20;
    localparam logic [ADDR_W-1:0] A_VAL_BASE  = 7'h40;

    localparam int unsigned B_ENABLE  = 0;
    localparam int unsigned B_CLR_EVT = 1;
    localparam int unsigned B_CLR_CYC = 2;
    localparam int unsigned B_DIVIDE  = 3;
    localparam int unsigned B_EXPORT  = 4;
    localparam int unsigned B_REGION  = 5;
    localparam int unsigned CYC_BIT   = 31;

    typedef struct packed {
        logic        excl_l1;
        logic        excl_l0;
        logic [15:0] evt;
    } evt_type_t;

    typedef struct packed {
        logic              enable;
        logic              divide;
        logic              export_on;
        logic              region_off;
        logic [WORD_W-1:0] cnten;
        logic [WORD_W-1:0] irqen;
        logic [WORD_W-1:0] ovf;
        logic [4:0]        sel;
    } ctrl_state_t;

    function automatic logic [WORD_W-1:0] type_to_word(evt_type_t t);
        return {t.excl_l1, t.excl_l0, 14'b0, t.evt};
    endfunction

endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
    import pmu_bank_pkg::*;
#(
    parameter int unsigned NUM_EVT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               priv_i,
    input  logic               clr_i,
    input  logic               type_wr_i,
    input  evt_type_t          type_wdata_i,
    input  logic               val_wr_i,
    input  logic [WORD_W-1:0]  val_wdata_i,
    output evt_type_t          type_o,
    output logic [WORD_W-1:0]  val_o,
    output logic               wrap_o
);

    typedef struct packed {
        evt_type_t         typ;
        logic [WORD_W-1:0] val;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       hit;
    logic       blocked;
    logic       inc;

    always_comb begin
        hit = 1'b0;
        for (int e = 0; e < int'(NUM_EVT); e++) begin
            if (st_q.typ.evt == 16'(e)) hit = evt_i[e];
        end
        blocked = priv_i ? st_q.typ.excl_l1 : st_q.typ.excl_l0;
        inc     = cnt_en_i & hit & ~blocked;

        st_d = st_q;
        if (type_wr_i) st_d.typ = type_wdata_i;
        if (clr_i)          st_d.val = '0;
        else if (val_wr_i)  st_d.val = val_wdata_i;
        else if (inc)       st_d.val = st_q.val + 1'b1;

        wrap_o = inc & ~clr_i & ~val_wr_i & (&st_q.val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign type_o = st_q.typ;
    assign val_o  = st_q.val;

    // R10: a value write overrides any increment in the same cycle
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr_i && !clr_i) |=> (val_o == $past(val_wdata_i)));

    // R4: without enable, write or clear the count holds
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_i && !val_wr_i && !clr_i) |=> $stable(val_o));

    // R2: clear leaves the counter at zero
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (val_o == '0));

    // R6: a reported wrap lands on zero
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (val_o == '0));

endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
    import pmu_bank_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              div_i,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] val_o,
    output logic              wrap_o
);

    typedef struct packed {
        logic [DIV_LOG2-1:0] pre;
        logic [WORD_W-1:0]   val;
    } cyc_state_t;

    cyc_state_t st_d, st_q;
    logic       tick;

    always_comb begin
        tick = run_i & (~div_i | (&st_q.pre));
        st_d = st_q;
        if (clr_i)               st_d.pre = '0;
        else if (run_i && div_i) st_d.pre = st_q.pre + 1'b1;

        if (clr_i)      st_d.val = '0;
        else if (wr_i)  st_d.val = wdata_i;
        else if (tick)  st_d.val = st_q.val + 1'b1;

        wrap_o = tick & ~clr_i & ~wr_i & (&st_q.val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.val;

    // R11: stopped cycle counter holds its value
    a_r11_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_i && !clr_i) |=> $stable(val_o));

    // R11: divided mode never steps by more than one
    a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && div_i && !wr_i && !clr_i) |=>
        ((val_o == $past(val_o)) || (val_o == $past(val_o) + 1'b1)));

    // R2: cycle clear leaves zero
    a_r2_cyc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (val_o == '0));

endmodule

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
    import pmu_bank_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] wrap_i,
    output logic [WORD_W-1:0] ctrl_o,
    output logic              enable_o,
    output logic              divide_o,
    output logic [WORD_W-1:0] cnten_o,
    output logic [WORD_W-1:0] irqen_o,
    output logic [WORD_W-1:0] ovf_o,
    output logic [4:0]        sel_o,
    output logic              clr_evt_o,
    output logic              clr_cyc_o,
    output logic              irq_o
);

    localparam logic [WORD_W-1:0] IMPL_MASK =
        32'h8000_0000 | ((32'h1 << NUM_CTR) - 32'h1);

    ctrl_state_t st_d, st_q;
    logic        wr_ctrl;

    always_comb begin
        wr_ctrl = wr_i && (addr_i == A_CTRL);
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.enable     = wdata_i[B_ENABLE];
            st_d.divide     = wdata_i[B_DIVIDE];
            st_d.export_on  = wdata_i[B_EXPORT];
            st_d.region_off = wdata_i[B_REGION];
        end
        if (wr_i && addr_i == A_CEN_SET) st_d.cnten = st_q.cnten | (wdata_i & IMPL_MASK);
        if (wr_i && addr_i == A_CEN_CLR) st_d.cnten = st_q.cnten & ~wdata_i;
        if (wr_i && addr_i == A_IEN_SET) st_d.irqen = st_q.irqen | (wdata_i & IMPL_MASK);
        if (wr_i && addr_i == A_IEN_CLR) st_d.irqen = st_q.irqen & ~wdata_i;
        if (wr_i && addr_i == A_OVF)     st_d.ovf   = st_q.ovf & ~wdata_i;
        st_d.ovf = st_d.ovf | (wrap_i & IMPL_MASK);
        if (wr_i && addr_i == A_SEL)     st_d.sel   = wdata_i[4:0];

        clr_evt_o = wr_ctrl & wdata_i[B_CLR_EVT];
        clr_cyc_o = wr_ctrl & wdata_i[B_CLR_CYC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o   = {16'h0, 5'(NUM_CTR), 4'h0, 1'b1, st_q.region_off,
                       st_q.export_on, st_q.divide, 2'b00, st_q.enable};
    assign enable_o = st_q.enable;
    assign divide_o = st_q.divide;
    assign cnten_o  = st_q.cnten;
    assign irqen_o  = st_q.irqen;
    assign ovf_o    = st_q.ovf;
    assign sel_o    = st_q.sel;
    assign irq_o    = |(st_q.ovf & st_q.irqen);

    // R3: cleared enable bits are zero afterwards
    a_r3_clear_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CEN_CLR) |=> ((cnten_o & $past(wdata_i)) == '0));

    // R3: set enable bits within the implemented set are one afterwards
    a_r3_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CEN_SET) |=>
        ((cnten_o & $past(wdata_i) & IMPL_MASK) == ($past(wdata_i) & IMPL_MASK)));

    // R7: cleared interrupt enables are zero afterwards
    a_r7_clear_irqen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_IEN_CLR) |=> ((irqen_o & $past(wdata_i)) == '0));

    // R6: a wrap always leaves its flag set, even against a clear
    a_r6_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wrap_i & IMPL_MASK)) |=>
        ((ovf_o & $past(wrap_i & IMPL_MASK)) == $past(wrap_i & IMPL_MASK)));

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pmu_bank_pkg::*;
#(
    parameter int unsigned NUM_CTR  = 4,
    parameter int unsigned NUM_EVT  = 32,
    parameter int unsigned DIV_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [6:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               priv_lvl,
    output logic               irq
);

    logic [WORD_W-1:0] ctrl_word, cnten, irqen, ovf, cyc_val, wrap_vec;
    logic              enable, divide, clr_evt, clr_cyc, cyc_wrap;
    logic [4:0]        sel;
    logic [NUM_CTR-1:0] ctr_wrap;
    evt_type_t         ctr_type [NUM_CTR];
    logic [WORD_W-1:0] ctr_val  [NUM_CTR];
    evt_type_t         type_wdata;

    assign type_wdata = '{excl_l1: reg_wdata[31], excl_l0: reg_wdata[30],
                          evt: reg_wdata[15:0]};

    pmu_ctrl_regs #(.NUM_CTR(NUM_CTR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .wrap_i(wrap_vec), .ctrl_o(ctrl_word),
        .enable_o(enable), .divide_o(divide), .cnten_o(cnten),
        .irqen_o(irqen), .ovf_o(ovf), .sel_o(sel), .clr_evt_o(clr_evt),
        .clr_cyc_o(clr_cyc), .irq_o(irq)
    );

    for (genvar k = 0; k < int'(NUM_CTR); k++) begin : g_ctr
        logic win_hit;
        logic type_wr;
        logic val_wr;
        assign win_hit = (sel == 5'(k));
        assign type_wr = reg_wr && ((reg_addr == A_TYPE_BASE + 7'(k)) ||
                                    (reg_addr == A_SEL_TYPE && win_hit));
        assign val_wr  = reg_wr && ((reg_addr == A_VAL_BASE + 7'(k)) ||
                                    (reg_addr == A_SEL_VAL && win_hit));

        pmu_event_counter #(.NUM_EVT(NUM_EVT)) u_ctr (
            .clk(clk), .rst_n(rst_n), .cnt_en_i(enable & cnten[k]),
            .evt_i(evt_pulse), .priv_i(priv_lvl), .clr_i(clr_evt),
            .type_wr_i(type_wr), .type_wdata_i(type_wdata),
            .val_wr_i(val_wr), .val_wdata_i(reg_wdata),
            .type_o(ctr_type[k]), .val_o(ctr_val[k]), .wrap_o(ctr_wrap[k])
        );
    end

    pmu_cycle_counter #(.DIV_LOG2(DIV_LOG2)) u_cyc (
        .clk(clk), .rst_n(rst_n), .run_i(enable & cnten[CYC_BIT]),
        .div_i(divide), .clr_i(clr_cyc),
        .wr_i(reg_wr && reg_addr == A_CYC), .wdata_i(reg_wdata),
        .val_o(cyc_val), .wrap_o(cyc_wrap)
    );

    always_comb begin
        wrap_vec = '0;
        for (int k = 0; k < int'(NUM_CTR); k++) wrap_vec[k] = ctr_wrap[k];
        wrap_vec[CYC_BIT] = cyc_wrap;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:               reg_rdata = ctrl_word;
            A_CEN_SET, A_CEN_CLR: reg_rdata = cnten;
            A_IEN_SET, A_IEN_CLR: reg_rdata = irqen;
            A_OVF:                reg_rdata = ovf;
            A_SEL:                reg_rdata = {27'b0, sel};
            A_CYC:                reg_rdata = cyc_val;
            default:              reg_rdata = '0;
        endcase
        for (int k = 0; k < int'(NUM_CTR); k++) begin
            if (reg_addr == A_TYPE_BASE + 7'(k)) reg_rdata = type_to_word(ctr_type[k]);
            if (reg_addr == A_VAL_BASE + 7'(k))  reg_rdata = ctr_val[k];
            if (sel == 5'(k) && reg_addr == A_SEL_TYPE) reg_rdata = type_to_word(ctr_type[k]);
            if (sel == 5'(k) && reg_addr == A_SEL_VAL)  reg_rdata = ctr_val[k];
        end
    end

    // R7: interrupt stays low while no counter has overflowed
    a_r7_irq_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf == '0) |-> !irq);

endmodule

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;

    localparam int NC = 4;
    localparam int NE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [6:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NE-1:0] evt_pulse = '0;
    logic          priv_lvl = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    perf_counter_bank #(.NUM_CTR(NC), .NUM_EVT(NE), .DIV_LOG2(6)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .priv_lvl(priv_lvl), .irq(irq)
    );

    // reference model state
    logic [31:0] m_cnt [NC];
    logic [15:0] m_evt [NC];
    bit          m_x1 [NC];
    bit          m_x0 [NC];
    logic [31:0] m_cyc, m_cen, m_ien, m_ovf;
    logic [5:0]  m_pre;
    bit          m_en, m_div, m_exp, m_reg;
    logic [4:0]  m_sel;

    localparam logic [31:0] MASK = 32'h8000_0000 | ((32'h1 << NC) - 1);

    function automatic logic [31:0] m_read(logic [6:0] a);
        int ai = int'(a);
        logic [31:0] r = '0;
        case (ai)
            0: r = {16'h0, 5'(NC), 4'h0, 1'b1, m_reg, m_exp, m_div, 2'b00, m_en};
            1, 2: r = m_cen;
            3, 4: r = m_ien;
            5: r = m_ovf;
            6: r = {27'b0, m_sel};
            9: r = m_cyc;
            default: r = '0;
        endcase
        for (int k = 0; k < NC; k++) begin
            if (ai == 32 + k || (ai == 7 && int'(m_sel) == k))
                r = {m_x1[k], m_x0[k], 14'b0, m_evt[k]};
            if (ai == 64 + k || (ai == 8 && int'(m_sel) == k))
                r = m_cnt[k];
        end
        return r;
    endfunction

    task automatic m_step(bit w, logic [6:0] a, logic [31:0] d,
                          logic [NE-1:0] ev, bit pv);
        int ai = int'(a);
        logic [31:0] wrap = '0;
        bit wctrl = w && ai == 0;
        bit run = m_en && m_cen[31];
        bit tick = run && (!m_div || m_pre == 6'd63);
        for (int k = 0; k < NC; k++) begin
            bit hit = (int'(m_evt[k]) < NE) ? ev[m_evt[k]] : 1'b0;
            bit ex = pv ? m_x1[k] : m_x0[k];
            bit inc = m_en && m_cen[k] && hit && !ex;
            bit vw = w && (ai == 64 + k || (ai == 8 && int'(m_sel) == k));
            bit tw = w && (ai == 32 + k || (ai == 7 && int'(m_sel) == k));
            if (wctrl && d[1]) m_cnt[k] = '0;
            else if (vw) m_cnt[k] = d;
            else if (inc) begin
                if (m_cnt[k] == 32'hFFFF_FFFF) wrap[k] = 1'b1;
                m_cnt[k] = m_cnt[k] + 1;
            end
            if (tw) begin
                m_x1[k] = d[31]; m_x0[k] = d[30]; m_evt[k] = d[15:0];
            end
        end
        if (wctrl && d[2]) begin
            m_pre = '0; m_cyc = '0;
        end else begin
            if (run && m_div) m_pre = m_pre + 1;
            if (w && ai == 9) m_cyc = d;
            else if (tick) begin
                if (m_cyc == 32'hFFFF_FFFF) wrap[31] = 1'b1;
                m_cyc = m_cyc + 1;
            end
        end
        if (wctrl) begin
            m_en = d[0]; m_div = d[3]; m_exp = d[4]; m_reg = d[5];
        end
        if (w && ai == 1) m_cen = m_cen | (d & MASK);
        if (w && ai == 2) m_cen = m_cen & ~d;
        if (w && ai == 3) m_ien = m_ien | (d & MASK);
        if (w && ai == 4) m_ien = m_ien & ~d;
        if (w && ai == 5) m_ovf = m_ovf & ~d;
        m_ovf = m_ovf | wrap;
        if (w && ai == 6) m_sel = d[4:0];
    endtask

    // one clock: drive at current (negedge) time, update model at the edge
    task automatic cyc(bit w, logic [6:0] a, logic [31:0] d,
                       logic [NE-1:0] ev, bit pv);
        reg_wr = w; reg_addr = a; reg_wdata = d; evt_pulse = ev; priv_lvl = pv;
        @(posedge clk);
        m_step(w, a, d, ev, pv);
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        cyc(1'b1, a, d, '0, 1'b0);
    endtask

    task automatic run(int n, logic [NE-1:0] ev, bit pv);
        for (int i = 0; i < n; i++) cyc(1'b0, 7'h00, 32'h0, ev, pv);
    endtask

    task automatic chk(logic [6:0] a, logic [31:0] exp, string req);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                     req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(bit exp, string req);
        #1;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
        end
    endtask

    function automatic logic [6:0] pick_addr();
        int r = int'($urandom % 16);
        if (r < 10) return 7'(r);
        if (r < 13) return 7'(32 + int'($urandom % (NC + 1)));
        return 7'(64 + int'($urandom % (NC + 1)));
    endfunction

    function automatic string req_of(logic [6:0] a);
        int ai = int'(a);
        if (ai == 0) return "R1";
        if (ai == 1 || ai == 2) return "R3";
        if (ai == 3 || ai == 4) return "R7";
        if (ai == 5) return "R6";
        if (ai == 6 || ai == 7 || ai == 8) return "R8";
        if (ai == 9) return "R11";
        if (ai >= 64) return "R4";
        return "R9";
    endfunction

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NC; k++) begin
            m_cnt[k] = '0; m_evt[k] = '0; m_x1[k] = 0; m_x0[k] = 0;
        end
        m_cyc = '0; m_cen = '0; m_ien = '0; m_ovf = '0; m_pre = '0;
        m_en = 0; m_div = 0; m_exp = 0; m_reg = 0; m_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(7'h00, 32'h0000_2040, "R12");
        chk(7'h01, 32'h0, "R12");
        chk(7'h05, 32'h0, "R12");
        chk(7'h40, 32'h0, "R12");
        chk_irq(1'b0, "R12");

        // R1 control readback
        wr(7'h00, 32'h46);
        chk(7'h00, 32'h0000_2040, "R1");
        wr(7'h00, 32'h39);
        chk(7'h00, 32'h0000_2079, "R1");
        wr(7'h00, 32'h0);

        // R3 enable pair
        wr(7'h01, 32'hFFFF_FFFF);
        chk(7'h01, 32'h8000_000F, "R3");
        chk(7'h02, 32'h8000_000F, "R3");
        wr(7'h02, ~32'h3);
        chk(7'h01, 32'h0000_0003, "R3");
        chk(7'h02, 32'h0000_0003, "R3");

        // R7 interrupt enable pair
        wr(7'h03, 32'hFFFF_FFFF);
        chk(7'h04, 32'h8000_000F, "R7");

        // R8 window, R9 type fields
        wr(7'h06, 32'h1);
        wr(7'h07, 32'hEA);
        chk(7'h21, 32'hEA, "R8");
        wr(7'h08, 32'hDEAD_BEEF);
        chk(7'h41, 32'hDEAD_BEEF, "R8");
        wr(7'h22, 32'hFFFF_FFFF);
        chk(7'h22, 32'hC000_FFFF, "R9");
        wr(7'h06, 32'h9);
        wr(7'h08, 32'h1234);
        chk(7'h08, 32'h0, "R8");
        for (int k = 0; k < NC; k++) chk(7'(64 + k), m_read(7'(64 + k)), "R8");

        // R4/R5/R6 overflow and privilege filter
        wr(7'h20, 32'h11);
        wr(7'h40, 32'hFFFF_FFF0);
        wr(7'h21, 32'h4000_0011);
        wr(7'h41, 32'h0);
        wr(7'h00, 32'h1);
        run(20, 32'h1 << 17, 1'b0);
        chk(7'h40, 32'h4, "R6");
        chk(7'h41, 32'h0, "R5");
        chk(7'h05, 32'h1, "R6");
        chk_irq(1'b1, "R7");
        run(5, 32'h1 << 17, 1'b1);
        chk(7'h41, 32'h5, "R5");
        chk(7'h40, 32'h9, "R4");
        wr(7'h05, 32'h1);
        chk(7'h05, 32'h0, "R6");
        chk_irq(1'b0, "R7");

        // R6 clear colliding with a new wrap
        wr(7'h40, 32'hFFFF_FFFF);
        cyc(1'b1, 7'h05, 32'h1, 32'h1 << 17, 1'b0);
        chk(7'h05, 32'h1, "R6");
        chk(7'h40, 32'h0, "R6");

        // R10 write wins over increment
        cyc(1'b1, 7'h40, 32'h55, 32'h1 << 17, 1'b0);
        chk(7'h40, 32'h55, "R10");

        // R2 event clear under a pulse
        cyc(1'b1, 7'h00, 32'h3, 32'h1 << 17, 1'b1);
        chk(7'h40, 32'h0, "R2");
        chk(7'h41, 32'h0, "R2");

        // R4 unsupported event number never counts
        wr(7'h23, 32'h3F);
        wr(7'h43, 32'h7);
        wr(7'h01, 32'h8);
        run(5, 32'hFFFF_FFFF, 1'b0);
        chk(7'h43, 32'h7, "R4");
        chk(7'h23, 32'h3F, "R9");

        // R11 cycle counter, plain and divided
        wr(7'h01, 32'h8000_0000);
        wr(7'h00, 32'h5);
        run(10, '0, 1'b0);
        chk(7'h09, 32'd10, "R11");
        wr(7'h00, 32'hD);
        run(128, '0, 1'b0);
        chk(7'h09, 32'd2, "R11");
        wr(7'h00, 32'h4);
        chk(7'h09, 32'h0, "R2");

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] ra = pick_addr();
            logic [6:0] wa = pick_addr();
            logic [31:0] wd = $urandom;
            bit w = ($urandom % 3) == 0;
            chk(ra, m_read(ra), req_of(ra));
            chk_irq(|(m_ovf & m_ien), "R7");
            if (wa == 7'h00) begin
                if ($urandom % 6 != 0) wd[1] = 1'b0;
                if ($urandom % 6 != 0) wd[2] = 1'b0;
                wd[0] = ($urandom % 4) != 0;
            end
            if (int'(wa) >= 64 || wa == 7'h08 || wa == 7'h09)
                if ($urandom % 2 == 0) wd = 32'hFFFF_FFF0 | 32'($urandom % 16);
            if (int'(wa) >= 32 && int'(wa) < 64 || wa == 7'h07)
                wd[15:0] = 16'($urandom % 40);
            if (wa == 7'h06) wd = 32'($urandom % 8);
            cyc(w, wa, wd, NE'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule